// File: doc/BRIEF.md
# Page Write Sequencer with Self-Timed Busy Cycle

This block sits behind the command decoder of a serial memory slave. When a page-write command is accepted it gathers the incoming data bytes into a page-sized buffer, noting which in-page slots were filled. It does not touch the storage array while bytes are arriving. The commit happens only when chip select is released cleanly on a byte boundary, the write latch was set when the command began, and the protection logic allows the page. The block then sweeps the marked slots into the array one strobe per cycle and holds a busy flag for a fixed number of clock cycles. When that time has passed it emits a one-cycle pulse, which the surrounding logic uses to clear its write enable latch.

Data bytes arrive on a valid/ready stream. A byte is taken on a cycle where `byte_valid` and `byte_ready` are both high. `byte_ready` is high only while a page-write transaction is open, so a producer that holds `byte_valid` outside a transaction, or during the busy cycle, is stalled and loses nothing. `byte_valid` may drop between bytes at any time. Control and status pins are plain single-cycle levels or pulses.

The block has no erase step. Only the slots that received a byte are written, so the other locations of the page keep their old contents. The array's physical programming time is modelled as a clock-cycle count, `CYCLE_LEN`.

Top module: `page_write_seq`

## Requirements
- R1: After reset, `busy`, `byte_ready`, `arr_we` and `cycle_done` are all 0.
- R2: `byte_ready` is 1 exactly while a transaction is open, from the cycle after an accepted `txn_start` until `abort` or `cs_rise`. It is never 1 while `busy` is 1.
- R3: The n-th accepted byte (counting from 0) goes to page offset (start offset + n) mod `PAGE_BYTES`, where the start offset is the low log2(`PAGE_BYTES`) bits of `start_addr`. The page bits above the offset stay fixed, so a later byte that wraps onto an earlier offset replaces it.
- R4: A commit happens on a `cs_rise` pulse only when all of these hold: `cs_on_boundary` is 1, at least one byte was accepted, `wel_set` was 1 with the `txn_start`, and `wr_allowed` is 1. `busy` rises in the next cycle.
- R5: A `cs_rise` with `cs_on_boundary` at 0 discards the transaction. No array write happens and `busy` stays 0.
- R6: If `wel_set` was 0 at `txn_start`, bytes are still accepted but dropped. The closing `cs_rise` writes nothing and leaves `busy` at 0.
- R7: If `wr_allowed` is 0 at the closing `cs_rise`, nothing is written and `busy` stays 0.
- R8: During the busy cycle, `arr_we` pulses once for each marked offset and for no other, in ascending offset order. Each pulse carries `arr_addr` = {page, offset} and the last byte accepted for that offset.
- R9: `busy` stays 1 for exactly `CYCLE_LEN` consecutive cycles after a commit.
- R10: `cycle_done` is a single-cycle pulse in the first cycle after `busy` falls. It never occurs without a preceding commit.
- R11: An `abort` pulse during an open transaction discards it. A later `cs_rise` writes nothing.
- R12: A `txn_start` that arrives while `busy` is 1 is ignored, and no transaction opens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_start | input | 1 | Pulse: page-write command accepted |
| start_addr | input | ADDR_W | First byte address of the transaction |
| wel_set | input | 1 | Write enable latch state at command time |
| byte_valid | input | 1 | Data byte available |
| byte_data | input | 8 | Data byte |
| byte_ready | output | 1 | Block takes a byte this cycle if valid |
| cs_rise | input | 1 | Pulse: chip select released |
| cs_on_boundary | input | 1 | Release came right after a whole byte |
| abort | input | 1 | Pulse: discard the open transaction |
| wr_allowed | input | 1 | Protection logic permits the addressed page |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_data | output | 8 | Array write data |
| busy | output | 1 | Self-timed write cycle in progress |
| cycle_done | output | 1 | Pulse: cycle finished, clear write latch |

## Verification
The bench builds the block with `ADDR_W` = 10, a 1 KiB array of 16 pages, so it can compare the whole array after every transaction. It keeps `PAGE_BYTES` at 64 and sets `CYCLE_LEN` to 80. With these values a burst of more than 64 bytes wraps the in-page offset. The full page sweep, which needs 64 cycles, fits inside the busy window. The exact busy length and the position of the done pulse can be measured cycle by cycle within a short run.

// File: rtl/pws_pkg.sv
package pws_pkg;
  typedef enum logic [1:0] {
    PWS_IDLE = 2'd0,
    PWS_FILL = 2'd1,
    PWS_DROP = 2'd2,
    PWS_PROG = 2'd3
  } pws_state_e;
endpackage

// File: rtl/pws_addr_track.sv
module pws_addr_track #(
  parameter int ADDR_W = 15,
  parameter int OFF_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              adv,
  output logic [ADDR_W-OFF_W-1:0] page,
  output logic [OFF_W-1:0]  off
);
  localparam int PAGE_W = ADDR_W - OFF_W;

  logic [PAGE_W-1:0] page_q;
  logic [OFF_W-1:0]  off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      off_q  <= '0;
    end else if (load) begin
      page_q <= load_addr[ADDR_W-1:OFF_W];
      off_q  <= load_addr[OFF_W-1:0];
    end else if (adv) begin
      off_q  <= off_q + 1'b1;
    end
  end

  assign page = page_q;
  assign off  = off_q;

  // R3
  page_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> (page_q == $past(page_q)));
  // R3
  off_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> (off_q == OFF_W'($past(off_q) + 1'b1)));
endmodule

// File: rtl/pws_page_buffer.sv
module pws_page_buffer #(
  parameter int PAGE_BYTES = 64,
  parameter int OFF_W      = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] wr_off,
  input  logic [7:0]       wr_data,
  input  logic [OFF_W-1:0] rd_off,
  output logic [7:0]       rd_data,
  output logic             rd_mark,
  output logic             any_mark
);
  logic [7:0] data_q [PAGE_BYTES];
  logic       mark_q [PAGE_BYTES];

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q[g] <= 8'h00;
        mark_q[g] <= 1'b0;
      end else if (clear) begin
        mark_q[g] <= 1'b0;
      end else if (wr_en && (wr_off == OFF_W'(g))) begin
        data_q[g] <= wr_data;
        mark_q[g] <= 1'b1;
      end
    end
  end

  assign rd_data = data_q[rd_off];
  assign rd_mark = mark_q[rd_off];

  always_comb begin
    any_mark = 1'b0;
    for (int i = 0; i < PAGE_BYTES; i++) any_mark = any_mark | mark_q[i];
  end

  // R3
  slot_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clear) |=> any_mark);
endmodule

// File: rtl/pws_cycle_timer.sv
module pws_cycle_timer #(
  parameter int CYCLE_LEN = 250000,
  parameter int CNT_W     = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             last,
  output logic             done,
  output logic [CNT_W-1:0] elapsed
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CYCLE_LEN - 1);

  logic             busy_q;
  logic             done_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        if (cnt_q == LAST_CNT) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          cnt_q  <= '0;
        end else begin
          cnt_q  <= cnt_q + 1'b1;
        end
      end else if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign elapsed = cnt_q;
  assign last    = busy_q && (cnt_q == LAST_CNT);

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last) |=> busy_q);
  // R10
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_q && $past(busy_q)));
  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/page_write_seq.sv
module page_write_seq
  import pws_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int PAGE_BYTES = 64,
  parameter int CYCLE_LEN  = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              wel_set,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  output logic              byte_ready,
  input  logic              cs_rise,
  input  logic              cs_on_boundary,
  input  logic              abort,
  input  logic              wr_allowed,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        arr_data,
  output logic              busy,
  output logic              cycle_done
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam int CNT_W  = $clog2(CYCLE_LEN);

  pws_state_e state_q, state_d;

  logic              open_start;
  logic              take_byte;
  logic              commit_go;
  logic [PAGE_W-1:0] page;
  logic [OFF_W-1:0]  wr_off;
  logic [OFF_W-1:0]  sweep_off;
  logic [7:0]        rd_data;
  logic              rd_mark;
  logic              any_mark;
  logic              tmr_busy;
  logic              tmr_last;
  logic              tmr_done;
  logic [CNT_W-1:0]  elapsed;
  logic              sweep_on;

  assign open_start = (state_q == PWS_IDLE) && txn_start;
  assign byte_ready = (state_q == PWS_FILL) || (state_q == PWS_DROP);
  assign take_byte  = byte_valid && byte_ready && (state_q == PWS_FILL);
  assign commit_go  = (state_q == PWS_FILL) && !abort && cs_rise &&
                      cs_on_boundary && any_mark && wr_allowed;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PWS_IDLE: if (txn_start) state_d = wel_set ? PWS_FILL : PWS_DROP;
      PWS_FILL: begin
        if (abort)          state_d = PWS_IDLE;
        else if (commit_go) state_d = PWS_PROG;
        else if (cs_rise)   state_d = PWS_IDLE;
      end
      PWS_DROP: if (abort || cs_rise) state_d = PWS_IDLE;
      PWS_PROG: if (tmr_last) state_d = PWS_IDLE;
      default:  state_d = PWS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PWS_IDLE;
    else        state_q <= state_d;
  end

  pws_addr_track #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_track (
    .clk(clk), .rst_n(rst_n),
    .load(open_start), .load_addr(start_addr),
    .adv(take_byte), .page(page), .off(wr_off)
  );

  pws_page_buffer #(.PAGE_BYTES(PAGE_BYTES), .OFF_W(OFF_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .clear(open_start),
    .wr_en(take_byte), .wr_off(wr_off), .wr_data(byte_data),
    .rd_off(sweep_off), .rd_data(rd_data), .rd_mark(rd_mark),
    .any_mark(any_mark)
  );

  pws_cycle_timer #(.CYCLE_LEN(CYCLE_LEN), .CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(commit_go),
    .busy(tmr_busy), .last(tmr_last), .done(tmr_done), .elapsed(elapsed)
  );

  assign sweep_off  = elapsed[OFF_W-1:0];
  assign sweep_on   = tmr_busy && (elapsed < CNT_W'(PAGE_BYTES));
  assign arr_we     = sweep_on && rd_mark;
  assign arr_addr   = {page, sweep_off};
  assign arr_data   = rd_data;
  assign busy       = tmr_busy;
  assign cycle_done = tmr_done;

  initial begin
    if (CYCLE_LEN <= PAGE_BYTES) $error("CYCLE_LEN must exceed PAGE_BYTES");
    if ((1 << OFF_W) != PAGE_BYTES) $error("PAGE_BYTES must be a power of two");
  end

  // R2
  ready_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_ready && busy));
  // R8
  we_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);
  // R4
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_rise && cs_on_boundary && wr_allowed));
  // R12
  state_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (state_q == PWS_PROG));
endmodule

// File: tb/page_write_seq_test.sv
`timescale 1ns/1ps
module page_write_seq_test;
  localparam int AW  = 10;
  localparam int PB  = 64;
  localparam int CYC = 80;
  localparam int MEMN = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txn_start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic wel_set = 1'b0;
  logic byte_valid = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic byte_ready;
  logic cs_rise = 1'b0;
  logic cs_on_boundary = 1'b0;
  logic abort = 1'b0;
  logic wr_allowed = 1'b0;
  logic arr_we;
  logic [AW-1:0] arr_addr;
  logic [7:0] arr_data;
  logic busy;
  logic cycle_done;

  int errors = 0;
  int checks = 0;
  int wr_cnt = 0;
  int order_bad = 0;
  int last_wa = -1;
  int cyc_cnt = 0;
  logic [7:0] mem [MEMN];
  logic [7:0] exp_mem [MEMN];

  always #10 clk = ~clk;

  page_write_seq #(.ADDR_W(AW), .PAGE_BYTES(PB), .CYCLE_LEN(CYC)) uut (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .start_addr(start_addr),
    .wel_set(wel_set), .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_ready(byte_ready), .cs_rise(cs_rise), .cs_on_boundary(cs_on_boundary),
    .abort(abort), .wr_allowed(wr_allowed), .arr_we(arr_we), .arr_addr(arr_addr),
    .arr_data(arr_data), .busy(busy), .cycle_done(cycle_done)
  );

  always @(posedge clk) begin
    if (arr_we) begin
      mem[arr_addr] <= arr_data;
      wr_cnt <= wr_cnt + 1;
      if (int'(arr_addr) <= last_wa) order_bad <= order_bad + 1;
      last_wa <= int'(arr_addr);
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int page_off(int base, int n);
    return (base + n) % PB;
  endfunction

  task automatic run_txn(int addr, int n, bit wel, bit bound, bit perm,
                         bit do_abort, bit poke);
    logic [7:0] stage [PB];
    bit marked [PB];
    int pbase;
    int distinct;
    int bcnt;
    int mism;
    bit commit;
    for (int i = 0; i < PB; i++) marked[i] = 1'b0;
    pbase  = addr & ~(PB - 1);
    commit = wel && bound && perm && !do_abort && (n > 0);
    @(negedge clk);
    txn_start = 1'b1; start_addr = AW'(addr); wel_set = wel;
    @(negedge clk);
    txn_start = 1'b0;
    check("R2 ready open", int'(byte_ready), 1);
    for (int i = 0; i < n; i++) begin
      int o;
      o = page_off(addr % PB, i);
      byte_valid = 1'b1;
      byte_data  = 8'($urandom);
      stage[o]   = byte_data;
      marked[o]  = 1'b1;
      @(negedge clk);
      byte_valid = 1'b0;
      if ($urandom % 4 == 0) @(negedge clk);
    end
    if (do_abort) begin
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
      check("R11 ready after abort", int'(byte_ready), 0);
    end
    wr_cnt = 0; last_wa = -1; order_bad = 0;
    cs_rise = 1'b1; cs_on_boundary = bound; wr_allowed = perm;
    @(negedge clk);
    cs_rise = 1'b0; cs_on_boundary = 1'b0; wr_allowed = 1'b0;
    bcnt = 0;
    while (busy && bcnt < CYC + 10) begin
      if (poke && bcnt == 3) begin
        txn_start = 1'b1; start_addr = '0; wel_set = 1'b1;
      end
      if (poke && bcnt == 4) begin
        txn_start = 1'b0;
        check("R12 ready stays low", int'(byte_ready), 0);
      end
      bcnt++;
      @(negedge clk);
    end
    txn_start = 1'b0;
    check("R9 busy length", bcnt, commit ? CYC : 0);
    check("R10 done pulse", int'(cycle_done), int'(commit));
    @(negedge clk);
    check("R10 done single", int'(cycle_done), 0);
    if (poke) check("R12 no txn opened", int'(byte_ready), 0);
    distinct = 0;
    for (int i = 0; i < PB; i++) if (marked[i]) begin
      distinct++;
      if (commit) exp_mem[pbase + i] = stage[i];
    end
    check("R8 write count", wr_cnt, commit ? distinct : 0);
    check("R8 ascending order", order_bad, 0);
    mism = 0;
    for (int a = 0; a < MEMN; a++) if (mem[a] !== exp_mem[a]) mism++;
    if (!wel)           check("R6 array unchanged", mism, 0);
    else if (!bound)    check("R5 array unchanged", mism, 0);
    else if (!perm)     check("R7 array unchanged", mism, 0);
    else if (do_abort)  check("R11 array unchanged", mism, 0);
    else                check("R3 R4 array contents", mism, 0);
  endtask

  initial begin : watchdog
    while (cyc_cnt < 150000) begin
      @(posedge clk);
      cyc_cnt++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=0", cyc_cnt);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int seed;
    seed = $urandom(32'd5150);
    for (int a = 0; a < MEMN; a++) begin
      mem[a] = 8'h00;
      exp_mem[a] = 8'h00;
    end
    repeat (3) @(negedge clk);
    check("R1 busy", int'(busy), 0);
    check("R1 ready", int'(byte_ready), 0);
    check("R1 we", int'(arr_we), 0);
    check("R1 done", int'(cycle_done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after release", int'(byte_ready), 0);
    // directed corners
    run_txn(64 * 2 + 5, 10, 1, 1, 1, 0, 0);   // R4 plain commit
    run_txn(64 * 3 + 60, 70, 1, 1, 1, 0, 0);  // R3 wrap with overwrite
    run_txn(64 * 4, 64, 1, 1, 1, 0, 0);       // R3 full page
    run_txn(64 * 5 + 7, 12, 1, 0, 1, 0, 0);   // R5 mid-byte release
    run_txn(64 * 6 + 1, 9, 0, 1, 1, 0, 0);    // R6 latch clear
    run_txn(64 * 7 + 2, 8, 1, 1, 0, 0, 0);    // R7 protected
    run_txn(64 * 8 + 3, 6, 1, 1, 1, 1, 0);    // R11 abort
    run_txn(64 * 9 + 4, 0, 1, 1, 1, 0, 0);    // R4 no bytes
    run_txn(64 * 10 + 11, 5, 1, 1, 1, 0, 1);  // R12 start during busy
    // random mix
    for (int t = 0; t < 24; t++) begin
      int a, n;
      bit w, b, p, ab;
      a  = int'($urandom % MEMN);
      n  = 1 + int'($urandom % 72);
      w  = ($urandom % 5) != 0;
      b  = ($urandom % 5) != 0;
      p  = ($urandom % 5) != 0;
      ab = ($urandom % 8) == 0;
      run_txn(a, n, w, b, p, ab, 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule